// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block is the transmit half of a clocked synchronous serial channel. Software writes a byte into a data register and then clears an empty flag in a status register. The block copies the byte into a shift register, sets the empty flag again and shifts the byte out on `txd_o`, least significant bit first. The serial clock is either generated on `sck_o` from a programmable divider (internal mode) or taken from `ext_sck_i` through a synchronizer (external mode).

The empty flag is checked again when the last bit's rising clock edge is reached. If software has already supplied another byte, that byte is loaded and the next frame follows with no idle phase between them. If not, an end flag is set, the data line keeps the final bit and the clock rests high. Two level interrupts, one for an empty buffer and one for the end of transmission, are the flags gated by their enable bits.

Register map (address on `addr_i`): 0 = data byte (read/write); 1 = status (bit 0 empty flag, bit 1 end flag); 2 = control (bit 0 empty interrupt enable, bit 1 end interrupt enable, bit 2 external clock mode); 3 = clock divider value N, each clock phase lasts N+1 system cycles.

Top module: `csync_tx`

## Requirements
- R1: After reset the status register reads 0x03 (empty flag 1, end flag 1), `sck_o` is 1, `txd_o` is 1 and both interrupt outputs are 0.
- R2: A write of the status register with bit 0 = 0 clears the empty flag and the end flag; the byte is copied into the shift register on the next cycle and the empty flag reads 1 again, while the end flag stays 0.
- R3: Each frame carries 8 bits, bit 0 first and bit 7 last; `txd_o` changes only on falling serial clock edges and is valid at the rising edge that follows.
- R4: In internal mode each frame has exactly 8 low pulses on `sck_o` and every clock phase lasts N+1 system cycles, N being the divider register.
- R5: If the empty flag is 0 at the rising edge of bit 7, the next byte is loaded and its first falling edge comes N+1 cycles later, the same as any other phase.
- R6: If the empty flag is 1 at the rising edge of bit 7, the end flag is set to 1, `sck_o` stays at 1 and `txd_o` keeps the value of bit 7.
- R7: `txi_o` equals the empty flag AND control bit 0; `tei_o` equals the end flag AND control bit 1.
- R8: With control bit 2 set, bits are shifted on falling edges of `ext_sck_i` (after a two-flop synchronizer) and are valid at its rising edges; `sck_o` stays at 1.
- R9: A status write with bit 0 = 1 changes neither flag and starts no transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| ext_sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Serial clock output, high when idle |
| txd_o | output | 1 | Serial data output |
| txi_o | output | 1 | Empty-buffer interrupt, level |
| tei_o | output | 1 | Transmit-end interrupt, level |

## Verification
The status register shows the clear one cycle after the write and the reload of the empty flag on the cycle after that, so the bench reads it on the second falling clock edge after the write. In internal mode the first falling edge of `sck_o` is due N+1 cycles after the load and every later edge N+1 cycles after the one before, including the edge that joins two chained frames; a monitor counts cycles between edges and samples `txd_o` on each rising edge. In external mode the synchronizer and edge detector delay the response by three cycles, so the bench reads `txd_o` at the instant it raises `ext_sck_i`, before the block can react, and reads the end flag only after several cycles have passed since the eighth rising edge.

// File: rtl/csync_tx_pkg.sv
package csync_tx_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  typedef struct packed {
    logic ext_clk;
    logic end_ie;
    logic empty_ie;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_FALL = 2'd1,
    ST_WAIT_RISE = 2'd2
  } shift_state_e;
endpackage

// File: rtl/csync_tx_regs.sv
module csync_tx_regs
  import csync_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              load_i,
  input  logic              end_set_i,
  output logic [DATA_W-1:0] tdata_o,
  output logic              empty_o,
  output logic              tend_o,
  output ctrl_t             ctrl_o,
  output logic [DIV_W-1:0]  div_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic [DATA_W-1:0] data_q;
  logic              empty_q, tend_q;
  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic              wr_stat_clr;

  assign wr_stat_clr = wr_en_i && (addr_i == ADDR_STAT) && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
      tend_q  <= 1'b1;
      ctrl_q  <= '0;
      div_q   <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_DATA) data_q <= wdata_i;
      if (wr_en_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_en_i && addr_i == ADDR_DIV)  div_q  <= wdata_i[DIV_W-1:0];
      // a load always re-arms empty
      if (load_i)           empty_q <= 1'b1;
      else if (wr_stat_clr) empty_q <= 1'b0;
      // a software clear wins over a coincident end event
      if (wr_stat_clr)      tend_q <= 1'b0;
      else if (end_set_i)   tend_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_DATA: rdata_o = data_q;
      ADDR_STAT: rdata_o = DATA_W'({tend_q, empty_q});
      ADDR_CTRL: rdata_o = DATA_W'(ctrl_q);
      default:   rdata_o = DATA_W'(div_q);
    endcase
  end

  assign tdata_o = data_q;
  assign empty_o = empty_q;
  assign tend_o  = tend_q;
  assign ctrl_o  = ctrl_q;
  assign div_o   = div_q;

  assert_empty_after_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> empty_q);

  assert_end_only_when_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_q) |-> empty_q);
endmodule

// File: rtl/csync_tx_clkgen.sv
module csync_tx_clkgen #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ext_mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_sck_i,
  output logic             fall_stb_o,
  output logic             rise_stb_o,
  output logic             sck_o
);
  logic [SYNC_N:0]  sync_q;   // [SYNC_N-1] synchronized, [SYNC_N] previous
  logic [DIV_W-1:0] cnt_q;
  logic             int_sck_q;
  logic             tick, ext_fall, ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-1:0], ext_sck_i};
  end

  assign ext_fall = sync_q[SYNC_N] & ~sync_q[SYNC_N-1];
  assign ext_rise = ~sync_q[SYNC_N] & sync_q[SYNC_N-1];

  assign tick = run_i && !ext_mode_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      int_sck_q <= 1'b1;
    end else if (!run_i || ext_mode_i) begin
      cnt_q     <= '0;
      int_sck_q <= 1'b1;
    end else if (tick) begin
      cnt_q     <= '0;
      int_sck_q <= ~int_sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (ext_mode_i) begin
      fall_stb_o = run_i & ext_fall;
      rise_stb_o = run_i & ext_rise;
    end else begin
      fall_stb_o = tick & int_sck_q;
      rise_stb_o = tick & ~int_sck_q;
    end
  end

  assign sck_o = int_sck_q;

  assert_strobe_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_stb_o, rise_stb_o}));
endmodule

// File: rtl/csync_tx_shifter.sv
module csync_tx_shifter
  import csync_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] tdata_i,
  input  logic              fall_stb_i,
  input  logic              rise_stb_i,
  output logic              load_o,
  output logic              end_set_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  shift_state_e      state_q;
  logic [DATA_W-1:0] sr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              txd_q;
  logic              last_rise;

  assign last_rise = (state_q == ST_WAIT_RISE) && rise_stb_i && (bit_q == LAST_BIT);
  assign load_o    = !empty_i && ((state_q == ST_IDLE) || last_rise);
  assign end_set_o = empty_i && last_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      bit_q   <= '0;
      txd_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (!empty_i) begin
          sr_q    <= tdata_i;
          bit_q   <= '0;
          state_q <= ST_WAIT_FALL;
        end
        ST_WAIT_FALL: if (fall_stb_i) begin
          txd_q   <= sr_q[0];
          state_q <= ST_WAIT_RISE;
        end
        ST_WAIT_RISE: if (rise_stb_i) begin
          if (bit_q == LAST_BIT) begin
            if (!empty_i) begin  // chain next frame
              sr_q    <= tdata_i;
              bit_q   <= '0;
              state_q <= ST_WAIT_FALL;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            sr_q    <= sr_q >> 1;
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_WAIT_FALL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign txd_o  = txd_q;

  assert_txd_moves_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall_stb_i && state_q == ST_WAIT_FALL) |=> $stable(txd_q));
endmodule

// File: rtl/csync_tx.sv
module csync_tx
  import csync_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_sck_i,
  output logic              sck_o,
  output logic              txd_o,
  output logic              txi_o,
  output logic              tei_o
);
  logic [DATA_W-1:0] tdata;
  logic              empty, tend, load, end_set, busy, fall_stb, rise_stb;
  ctrl_t             ctrl;
  logic [DIV_W-1:0]  div;

  csync_tx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .load_i(load), .end_set_i(end_set), .tdata_o(tdata),
    .empty_o(empty), .tend_o(tend), .ctrl_o(ctrl), .div_o(div)
  );

  csync_tx_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clkgen (
    .clk_i, .rst_ni, .run_i(busy), .ext_mode_i(ctrl.ext_clk), .div_i(div),
    .ext_sck_i, .fall_stb_o(fall_stb), .rise_stb_o(rise_stb), .sck_o
  );

  csync_tx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i, .rst_ni, .empty_i(empty), .tdata_i(tdata),
    .fall_stb_i(fall_stb), .rise_stb_i(rise_stb),
    .load_o(load), .end_set_o(end_set), .busy_o(busy), .txd_o
  );

  assign txi_o = empty & ctrl.empty_ie;
  assign tei_o = tend & ctrl.end_ie;

  assert_idle_sck_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sck_o);

  assert_ext_sck_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.ext_clk |=> sck_o);
endmodule

// File: tb/csync_tx_tb.sv
module csync_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_sck = 1'b1;
  logic       sck, txd, txi, tei;

  always #10 clk = ~clk;  // 50 MHz

  csync_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_sck_i(ext_sck), .sck_o(sck), .txd_o(txd),
    .txi_o(txi), .tei_o(tei)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #2; d = rdata;
  endtask

  // monitor for internal mode
  int        cur_div = 0;
  bit        mon_en = 1'b0, chain_mode = 1'b0;
  int        chain_frames = 0;
  logic      sck_prev = 1'b1;
  int        since_edge = 0;
  int        rx_bits = 0, falls = 0, phase_bad = 0, phase_seen = 0;
  logic [7:0] rx_sh = 8'd0;
  logic [7:0] rx_buf [0:7];
  int        rx_cnt = 0;

  always @(negedge clk) begin
    since_edge++;
    if (mon_en && sck !== sck_prev) begin
      if (!sck) begin
        falls++;
        if (rx_bits != 0 || (chain_mode && chain_frames > 0)) begin
          phase_seen++;
          if (since_edge != cur_div + 1) phase_bad++;
        end
      end else begin
        phase_seen++;
        if (since_edge != cur_div + 1) phase_bad++;
        rx_sh = {txd, rx_sh[7:1]};
        rx_bits++;
        if (rx_bits == 8) begin
          if (rx_cnt < 8) rx_buf[rx_cnt] = rx_sh;
          rx_cnt++;
          rx_bits = 0;
          if (chain_mode) chain_frames++;
        end
      end
      since_edge = 0;
    end
    sck_prev = sck;
  end

  task automatic wait_end(output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(2'd1, s);
      if (s[1]) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    bit ok;
    logic [7:0] bytes [0:3];
    int divs [0:3];
    bytes[0] = 8'hA5; bytes[1] = 8'h01; bytes[2] = 8'h80; bytes[3] = 8'h3C;
    divs[0] = 0; divs[1] = 1; divs[2] = 2; divs[3] = 5;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_rd(2'd1, s);
    chk(s == 8'h03, "R1 status", s, 8'h03);
    chk(sck === 1'b1 && txd === 1'b1, "R1 sck/txd", {sck, txd}, 2'b11);
    chk(txi === 1'b0 && tei === 1'b0, "R1 irq", {txi, tei}, 2'b00);

    // R7 interrupt gating
    bus_wr(2'd2, 8'h01); #2;
    chk(txi === 1'b1 && tei === 1'b0, "R7 txi only", {txi, tei}, 2'b10);
    bus_wr(2'd2, 8'h02); #2;
    chk(txi === 1'b0 && tei === 1'b1, "R7 tei only", {txi, tei}, 2'b01);
    bus_wr(2'd2, 8'h00);

    // R9 status write with bit0=1 is ignored
    mon_en = 1'b1;
    bus_wr(2'd0, 8'h55);
    bus_wr(2'd1, 8'h01);
    repeat (40) @(negedge clk);
    bus_rd(2'd1, s);
    chk(s == 8'h03, "R9 flags unchanged", s, 8'h03);
    chk(falls == 0, "R9 no transmission", falls, 0);

    // single frames, sweep divider and data
    for (int d = 0; d < 4; d++) begin
      cur_div = divs[d];
      bus_wr(2'd3, 8'(cur_div));
      for (int b = 0; b < 4; b++) begin
        rx_cnt = 0; falls = 0; phase_bad = 0; phase_seen = 0;
        bus_wr(2'd0, bytes[b]);
        bus_wr(2'd1, 8'h00);
        bus_rd(2'd1, s);
        chk(s == 8'h01, "R2 reload empty, end cleared", s, 8'h01);
        wait_end(ok);
        chk(ok, "R6 end flag set", ok, 1);
        repeat (2 * cur_div + 6) @(negedge clk);
        chk(rx_cnt == 1 && rx_buf[0] == bytes[b], "R3 byte LSB first", rx_buf[0], bytes[b]);
        chk(falls == 8, "R4 eight pulses", falls, 8);
        chk(phase_bad == 0 && phase_seen == 15, "R4 phase length", phase_bad, 0);
        chk(sck === 1'b1 && txd === bytes[b][7], "R6 idle hold", {sck, txd}, {1'b1, bytes[b][7]});
      end
    end

    // R5 chained frames
    cur_div = 1;
    bus_wr(2'd3, 8'd1);
    bus_wr(2'd2, 8'h01);
    rx_cnt = 0; falls = 0; phase_bad = 0; phase_seen = 0;
    chain_mode = 1'b1; chain_frames = 0;
    bus_wr(2'd0, 8'h96);
    bus_wr(2'd1, 8'h00);
    @(negedge clk); #2;
    chk(txi === 1'b1, "R7 txi after load", txi, 1);
    bus_wr(2'd0, 8'h0F);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, s);
    chk(s[1] == 1'b0, "R5 no end while chaining", s, 0);
    for (int i = 0; i < 200 && !(txi === 1'b1); i++) @(negedge clk);
    bus_wr(2'd0, 8'hE1);
    bus_wr(2'd1, 8'h00);
    wait_end(ok);
    repeat (8) @(negedge clk);
    chk(ok && rx_cnt == 3, "R5 frame count", rx_cnt, 3);
    chk(rx_buf[0] == 8'h96 && rx_buf[1] == 8'h0F && rx_buf[2] == 8'hE1, "R5 order",
        {rx_buf[0], rx_buf[1], rx_buf[2]}, 24'h960FE1);
    chk(phase_bad == 0 && phase_seen == 47, "R5 no gap", phase_seen, 47);
    chk(falls == 24, "R4 pulses in chain", falls, 24);
    chain_mode = 1'b0;
    bus_wr(2'd2, 8'h02); #2;
    chk(tei === 1'b1, "R7 tei after end", tei, 1);

    // R8 external clock
    mon_en = 1'b0;
    bus_wr(2'd2, 8'h04);
    for (int b = 0; b < 2; b++) begin
      logic [7:0] exp_b, got;
      exp_b = (b == 0) ? 8'h5A : 8'hC3;
      got = 8'h00;
      bus_wr(2'd0, exp_b);
      bus_wr(2'd1, 8'h00);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); ext_sck = 1'b0;
        repeat (6) @(negedge clk);
        got = {txd, got[7:1]};
        ext_sck = 1'b1;
        if (i == 4) chk(sck === 1'b1, "R8 sck_o high", sck, 1);
        repeat (6) @(negedge clk);
      end
      chk(got == exp_b, "R8 external byte", got, exp_b);
      bus_rd(2'd1, s);
      chk(s == 8'h03, "R8 end after frame", s, 8'h03);
      chk(txd === exp_b[7], "R6 ext hold", txd, exp_b[7]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule